// File: doc/BRIEF.md
# ADC Scan Phase Sequencer

This block generates the phase timing for a successive-approximation A/D converter that scans one to four channels in turn. A scan can be started by an internal timer trigger or by an external trigger pin. The start delay depends on which of the two started the scan. After that delay the sequencer runs the phases in this order: an optional dedicated sample-and-hold phase, an optional offset-cancel phase, a sample-then-convert pair for each channel, and a short completion phase. When the completion phase ends it raises a sticky conversion-end flag.

The analog converter is outside the block. Its result arrives on `conv_data_i`. At the last cycle of each channel's conversion phase the sequencer pulses a write strobe. The strobe comes together with the channel index and the converter value, so a result register outside the block can capture it. Two mode bits and the channel count are latched when a trigger is accepted. They stay constant until the scan ends, whatever the inputs do in the meantime.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset `busy_o` and `end_flag_o` are 0, `wr_stb_o` is 0, `chan_o` is 0 and `phase_o` is 7'b0000001 (idle). `chan_o` is 0 whenever the block is idle.
- R2: A scan started by `tmr_trig_i` spends 11 cycles in the start delay. A scan started by `ext_trig_i` spends 15 cycles there. When both triggers are high in the same cycle, the timer trigger wins and the delay is 11.
- R3: When the latched `sh_en_i` is 1, a 30-cycle dedicated sample-and-hold phase follows the delay. When it is 0, that phase is skipped.
- R4: When the latched `ofc_byp_i` is 0, a 50-cycle offset-cancel phase runs next. When it is 1, that phase is skipped.
- R5: The scan covers n = `chan_cnt_i`+1 channels, taken in ascending order from 0 to n-1. Each channel takes 50 cycles: 20 cycles of common sample-and-hold, then 30 cycles of conversion.
- R6: A 4-cycle completion phase follows the last channel. `end_flag_o` becomes 1 exactly 50n + delay + 30·sh + 50·(1−byp) + 4 rising edges after the edge that accepted the trigger. With the timer trigger this gives 50n+65, 50n+15, 50n+95 and 50n+45.
- R7: `wr_stb_o` is high for exactly one cycle, the last cycle of each conversion phase. In that cycle `chan_o` holds the channel index and `wr_data_o` equals `conv_data_i`.
- R8: Triggers that arrive while `busy_o` is 1 are ignored and do not restart or lengthen the scan.
- R9: `sh_en_i`, `ofc_byp_i` and `chan_cnt_i` are latched when a trigger is accepted. Changing them during a scan has no effect on that scan.
- R10: `end_flag_o` stays 1 until a cycle with `end_clr_i` = 1. If the flag is set and cleared in the same cycle, the set wins.
- R11: `busy_o` goes high on the edge that accepts a trigger and stays high until the edge that sets `end_flag_o`, where it falls.
- R12: `phase_o` is one-hot. Bit 0 is idle, bit 1 is the start delay, bit 2 is the dedicated sample-and-hold, bit 3 is offset cancel, bit 4 is common sample-and-hold, bit 5 is conversion and bit 6 is completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_trig_i | input | 1 | Start request from the timer module |
| ext_trig_i | input | 1 | Start request from the external pin |
| sh_en_i | input | 1 | Enables the dedicated sample-and-hold phase |
| ofc_byp_i | input | 1 | Skips the offset-cancel phase |
| chan_cnt_i | input | CH_W | Number of channels minus one |
| conv_data_i | input | DATA_W | Converter result |
| end_clr_i | input | 1 | Clears the conversion-end flag |
| busy_o | output | 1 | Scan in progress |
| end_flag_o | output | 1 | Sticky conversion-end flag |
| phase_o | output | 7 | One-hot phase strobes |
| chan_o | output | CH_W | Current channel index |
| wr_stb_o | output | 1 | Result write strobe |
| wr_data_o | output | DATA_W | Result to be written |

## Verification
The hardest cases to reach from the ports involve a scan already in progress. Fresh triggers and altered mode bits or channel count arrive partway through, and the scan must keep its original length and channel count. The other hard case is a flag set that coincides with a clear. Directed scans raise both triggers together with inverted configuration inputs in the middle of a scan. Another directed scan holds the clear high across the flag-set edge. Random scans then cover all combinations of trigger source, mode bits and channel count, with the timing of every write strobe and the flag checked against computed cycle counts.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_DLY  = 3'd1,
    PH_DSH  = 3'd2,
    PH_OFC  = 3'd3,
    PH_CSH  = 3'd4,
    PH_CNV  = 3'd5,
    PH_END  = 3'd6
  } phase_e;

  localparam int unsigned NUM_PH = 7;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_trig_arb.sv
module adc_trig_arb #(
  parameter int unsigned CH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            idle_i,
  input  logic            tmr_trig_i,
  input  logic            ext_trig_i,
  input  logic            sh_en_i,
  input  logic            ofc_byp_i,
  input  logic [CH_W-1:0] chan_cnt_i,
  output logic            accept_o,
  output logic            ext_sel_o,
  output logic            sh_q_o,
  output logic            byp_q_o,
  output logic [CH_W-1:0] last_ch_q_o
);

  // timer trigger has priority over the external pin
  assign accept_o  = idle_i && (tmr_trig_i || ext_trig_i);
  assign ext_sel_o = !tmr_trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q_o      <= 1'b0;
      byp_q_o     <= 1'b0;
      last_ch_q_o <= '0;
    end else if (accept_o) begin
      sh_q_o      <= sh_en_i;
      byp_q_o     <= ofc_byp_i;
      last_ch_q_o <= chan_cnt_i;
    end
  end

endmodule

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_m1_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= len_m1_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/adc_end_flag.sv
module adc_end_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set wins over clear
    else if (clr_i)  flag_o <= 1'b0;
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DLY_TMR = 11,
  parameter int unsigned DLY_EXT = 15,
  parameter int unsigned DSH_LEN = 30,
  parameter int unsigned OFC_LEN = 50,
  parameter int unsigned CSH_LEN = 20,
  parameter int unsigned CNV_LEN = 30,
  parameter int unsigned END_LEN = 4,
  parameter int unsigned MAX_CH  = 4,
  parameter int unsigned DATA_W  = 12,
  localparam int unsigned CH_W   = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_trig_i,
  input  logic              ext_trig_i,
  input  logic              sh_en_i,
  input  logic              ofc_byp_i,
  input  logic [CH_W-1:0]   chan_cnt_i,
  input  logic [DATA_W-1:0] conv_data_i,
  input  logic              end_clr_i,
  output logic              busy_o,
  output logic              end_flag_o,
  output logic [6:0]        phase_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              wr_stb_o,
  output logic [DATA_W-1:0] wr_data_o
);

  localparam int unsigned MAX_LEN = max2(max2(max2(DLY_TMR, DLY_EXT), max2(DSH_LEN, OFC_LEN)),
                                         max2(max2(CSH_LEN, CNV_LEN), END_LEN));
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

  localparam logic [CNT_W-1:0] L_TMR = CNT_W'(DLY_TMR - 1);
  localparam logic [CNT_W-1:0] L_EXT = CNT_W'(DLY_EXT - 1);
  localparam logic [CNT_W-1:0] L_DSH = CNT_W'(DSH_LEN - 1);
  localparam logic [CNT_W-1:0] L_OFC = CNT_W'(OFC_LEN - 1);
  localparam logic [CNT_W-1:0] L_CSH = CNT_W'(CSH_LEN - 1);
  localparam logic [CNT_W-1:0] L_CNV = CNT_W'(CNV_LEN - 1);
  localparam logic [CNT_W-1:0] L_END = CNT_W'(END_LEN - 1);

  phase_e           state_q, state_d;
  logic             accept, ext_sel, sh_q, byp_q;
  logic [CH_W-1:0]  last_ch_q, ch_q;
  logic             tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_len;
  logic             ch_inc, ch_clr, flag_set;

  adc_trig_arb #(.CH_W(CH_W)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idle_i      (state_q == PH_IDLE),
    .tmr_trig_i  (tmr_trig_i),
    .ext_trig_i  (ext_trig_i),
    .sh_en_i     (sh_en_i),
    .ofc_byp_i   (ofc_byp_i),
    .chan_cnt_i  (chan_cnt_i),
    .accept_o    (accept),
    .ext_sel_o   (ext_sel),
    .sh_q_o      (sh_q),
    .byp_q_o     (byp_q),
    .last_ch_q_o (last_ch_q)
  );

  adc_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .len_m1_i (tmr_len),
    .last_o   (tmr_last)
  );

  adc_end_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (end_clr_i),
    .flag_o (end_flag_o)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_len  = '0;
    ch_inc   = 1'b0;
    ch_clr   = 1'b0;
    flag_set = 1'b0;
    unique case (state_q)
      PH_IDLE: if (accept) begin
        state_d  = PH_DLY;
        tmr_load = 1'b1;
        tmr_len  = ext_sel ? L_EXT : L_TMR;
        ch_clr   = 1'b1;
      end
      PH_DLY: if (tmr_last) begin
        tmr_load = 1'b1;
        if (sh_q) begin
          state_d = PH_DSH;
          tmr_len = L_DSH;
        end else if (!byp_q) begin
          state_d = PH_OFC;
          tmr_len = L_OFC;
        end else begin
          state_d = PH_CSH;
          tmr_len = L_CSH;
        end
      end
      PH_DSH: if (tmr_last) begin
        tmr_load = 1'b1;
        if (!byp_q) begin
          state_d = PH_OFC;
          tmr_len = L_OFC;
        end else begin
          state_d = PH_CSH;
          tmr_len = L_CSH;
        end
      end
      PH_OFC: if (tmr_last) begin
        tmr_load = 1'b1;
        state_d  = PH_CSH;
        tmr_len  = L_CSH;
      end
      PH_CSH: if (tmr_last) begin
        tmr_load = 1'b1;
        state_d  = PH_CNV;
        tmr_len  = L_CNV;
      end
      PH_CNV: if (tmr_last) begin
        tmr_load = 1'b1;
        if (ch_q == last_ch_q) begin
          state_d = PH_END;
          tmr_len = L_END;
        end else begin
          state_d = PH_CSH;
          tmr_len = L_CSH;
          ch_inc  = 1'b1;
        end
      end
      PH_END: if (tmr_last) begin
        state_d  = PH_IDLE;
        flag_set = 1'b1;
        ch_clr   = 1'b1;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      if (ch_clr)      ch_q <= '0;
      else if (ch_inc) ch_q <= ch_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_PH; g++) begin : g_ph
    assign phase_o[g] = (state_q == phase_e'(g));
  end

  assign busy_o    = (state_q != PH_IDLE);
  assign chan_o    = ch_q;
  assign wr_stb_o  = (state_q == PH_CNV) && tmr_last;
  assign wr_data_o = conv_data_i;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int unsigned CH_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            end_clr_i,
  input logic            busy_o,
  input logic            end_flag_o,
  input logic [6:0]      phase_o,
  input logic [CH_W-1:0] chan_o,
  input logic            wr_stb_o
);

  AST_PHASE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(phase_o) == 1);  // R12

  AST_IDLE_CHAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[0] |-> chan_o == '0);  // R1

  AST_DLY_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o[0] && !phase_o[1] |=> !phase_o[1]);  // R8

  AST_WR_IN_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> phase_o[5]);  // R7

  AST_WR_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |=> !wr_stb_o);  // R7

  AST_CONV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[5] && !wr_stb_o |=> phase_o[5] && $stable(chan_o));  // R5

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_flag_o && !end_clr_i && !busy_o |=> end_flag_o);  // R10

  AST_BUSY_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> end_flag_o);  // R11

  AST_FLAG_AFTER_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_flag_o) |-> $past(phase_o[6]));  // R6

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .end_clr_i  (end_clr_i),
  .busy_o     (busy_o),
  .end_flag_o (end_flag_o),
  .phase_o    (phase_o),
  .chan_o     (chan_o),
  .wr_stb_o   (wr_stb_o)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;

  localparam int CH_W = 2;
  localparam int DW   = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tmr_trig = 1'b0, ext_trig = 1'b0, sh_en = 1'b0, ofc_byp = 1'b0, end_clr = 1'b0;
  logic [CH_W-1:0] chan_cnt = '0;
  logic [DW-1:0] conv_data = '0;
  logic          busy, end_flag, wr_stb;
  logic [6:0]    phase;
  logic [CH_W-1:0] chan;
  logic [DW-1:0] wr_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  adc_scan_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .tmr_trig_i(tmr_trig), .ext_trig_i(ext_trig),
    .sh_en_i(sh_en), .ofc_byp_i(ofc_byp), .chan_cnt_i(chan_cnt), .conv_data_i(conv_data),
    .end_clr_i(end_clr), .busy_o(busy), .end_flag_o(end_flag), .phase_o(phase),
    .chan_o(chan), .wr_stb_o(wr_stb), .wr_data_o(wr_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_total(input bit ext, input bit sh, input bit byp, input int nm1);
    return (ext ? 15 : 11) + (sh ? 30 : 0) + (byp ? 0 : 50) + 50 * (nm1 + 1) + 4;
  endfunction

  // both: raise both triggers; disturb: mid-scan triggers and config flips; hold_clr: clear held over set
  task automatic run_scan(input bit ext, input bit both, input bit sh, input bit byp,
                          input int nm1, input bit disturb, input bit hold_clr, input string tag);
    bit ext_eff = ext && !both;
    int t_exp = exp_total(ext_eff, sh, byp, nm1);
    int pre   = t_exp - 50 * (nm1 + 1) - 4;
    int e     = 0;
    int nwr   = 0;
    bit busy_drop = 1'b0;
    @(negedge clk);
    sh_en = sh; ofc_byp = byp; chan_cnt = CH_W'(nm1);
    tmr_trig = !ext || both; ext_trig = ext || both;
    @(negedge clk);
    tmr_trig = 1'b0; ext_trig = 1'b0;
    end_clr = hold_clr;
    chk(busy == 1'b1, "R11 busy on accept", busy, 1);
    chk(phase == 7'b0000010, "R12 delay phase", phase, 2);
    while (!end_flag && e < 1000) begin
      if (!busy) busy_drop = 1'b1;
      if (wr_stb) begin
        chk(chan == CH_W'(nwr), "R5 channel order", chan, nwr);
        chk(e == pre + 50 * (nwr + 1) - 1, "R7 strobe cycle", e, pre + 50 * (nwr + 1) - 1);
        chk(wr_data == conv_data, "R7 write data", wr_data, conv_data);
        nwr++;
      end
      if (e == t_exp - 1) chk(phase == 7'b1000000, "R12 completion phase", phase, 64);
      if (e == pre) chk(phase == 7'b0010000, "R12 first common s/h", phase, 16);
      if (disturb && e == 40) begin
        tmr_trig = 1'b1; ext_trig = 1'b1;
        sh_en = ~sh; ofc_byp = ~byp; chan_cnt = ~CH_W'(nm1);
      end
      if (disturb && e == 42) begin
        tmr_trig = 1'b0; ext_trig = 1'b0;
      end
      conv_data = DW'($urandom);
      @(negedge clk);
      e++;
    end
    chk(e == t_exp, {tag, " total time"}, e, t_exp);
    chk(nwr == nm1 + 1, "R5 channel count", nwr, nm1 + 1);
    chk(busy == 1'b0, "R11 busy low at flag", busy, 0);
    chk(!busy_drop, "R11 busy held", busy_drop, 0);
    if (hold_clr) begin
      @(negedge clk);
      end_clr = 1'b0;
      chk(end_flag == 1'b0, "R10 clear after set", end_flag, 0);
    end else begin
      repeat (3) @(negedge clk);
      chk(end_flag == 1'b1, "R10 flag held", end_flag, 1);
      chk(busy == 1'b0, "R8 no restart", busy, 0);
      end_clr = 1'b1;
      @(negedge clk);
      end_clr = 1'b0;
      chk(end_flag == 1'b0, "R10 flag cleared", end_flag, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && end_flag == 1'b0, "R1 reset busy/flag", {busy, end_flag}, 0);
    chk(phase == 7'b0000001, "R1 reset phase", phase, 1);
    chk(wr_stb == 1'b0 && chan == '0, "R1 reset strobe/chan", {wr_stb, chan}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_scan(1'b0, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R2 R6 tmr sh0 ofc0");
    run_scan(1'b1, 1'b0, 1'b0, 1'b0, 0, 1'b0, 1'b0, "R2 ext delay");
    run_scan(1'b1, 1'b1, 1'b0, 1'b1, 1, 1'b0, 1'b0, "R2 both triggers");
    run_scan(1'b0, 1'b0, 1'b1, 1'b0, 3, 1'b0, 1'b0, "R3 dedicated s/h");
    run_scan(1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b0, 1'b0, "R4 ofc bypass");
    run_scan(1'b0, 1'b0, 1'b1, 1'b1, 0, 1'b1, 1'b0, "R8 R9 mid-scan disturb");
    run_scan(1'b1, 1'b0, 1'b0, 1'b0, 3, 1'b1, 1'b0, "R9 config latched");
    run_scan(1'b0, 1'b0, 1'b1, 1'b1, 1, 1'b0, 1'b1, "R10 set wins");
    for (int i = 0; i < 24; i++) begin
      run_scan(1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
               int'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0), 1'b0, "R6 random");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule